// File: doc/BRIEF.md
# Sector Erase Acceptance Window Controller

This block models the device-side time-out that follows a sector erase request in a NOR flash command state machine. The first accepted sector erase command does three things. It opens an acceptance window, marks that sector in a selection bitmap, and starts a cycle-counted time-out. Each further sector erase command that arrives while the window is open adds its sector to the bitmap and restarts the full time-out. When the time-out runs out, the window-closed status bit rises. That edge marks the start of the internal erase, which is modelled as a fixed-length busy period.

During the busy period the block drops every command except a suspend request. A suspend freezes the busy count until a resume command arrives. Status reads taken while the erase is running flip a toggle bit. A chip erase command skips the window and starts the busy period at once, with every sector selected. When the erase completes, the window-closed bit falls, the bitmap clears and the block is ready for new commands.

Commands arrive already decoded: a one-cycle valid strobe, a 3-bit operation code and a sector index.

Top module: `erase_window_ctl`

## Requirements
- R1: After reset, `win_open`, `win_closed`, `ers_susp` and `tgl_bit` are low and `sel_map` is all zeros.
- R2: In the idle state, a command with `cmd_op` = 1 (sector erase) and `cmd_sec` < NUM_SECT opens the window from the next cycle. In that cycle `win_open` is high, `win_closed` is low and bit `cmd_sec` of `sel_map` is set.
- R3: The window closes exactly WIN_CYC cycles after the last accepted sector command. From that cycle `win_open` is low and `win_closed` is high.
- R4: A valid sector command accepted while the window is open sets its bit and restarts the full time-out. This also holds when it arrives in the very cycle the window would have expired: in that case the restart takes priority.
- R5: A sector command whose index is NUM_SECT or above is ignored in every state. It sets no bit and does not restart the window.
- R6: In the idle state, a command with `cmd_op` = 2 (chip erase) opens no window. From the next cycle `win_closed` is high and every bit of `sel_map` is set.
- R7: The erase stays busy for ERASE_CYC non-suspended cycles. In the following cycle `win_closed` falls, `sel_map` clears to zero and the block is idle again.
- R8: While erasing and not suspended, every command other than `cmd_op` = 3 (suspend) is ignored. Such commands do not change `sel_map` and do not move the completion time.
- R9: A suspend during the erase raises `ers_susp` and freezes the busy count. While suspended, only `cmd_op` = 4 (resume) is acted on. Completion is delayed by exactly the number of cycles spent suspended. A suspend that arrives in the final busy cycle is dropped, and the erase completes.
- R10: A `stat_rd` pulse in a cycle where the erase is running and not suspended inverts `tgl_bit`. Reads at any other time leave it unchanged.
- R11: Operation codes 0 and 5 to 7 are ignored in every state. Chip erase, suspend and resume are also ignored while the window is open or idle, except for the chip erase case that R6 covers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_vld | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 3 | Operation: 1 sector erase, 2 chip erase, 3 suspend, 4 resume, others none |
| cmd_sec | input | SECT_W | Sector index for a sector erase command |
| stat_rd | input | 1 | Status read strobe |
| win_open | output | 1 | High while further sector commands are accepted |
| win_closed | output | 1 | High from the end of the time-out until the erase completes (status bit 3) |
| ers_susp | output | 1 | High while the erase is suspended |
| tgl_bit | output | 1 | Toggles on status reads during the running erase (status bit 6) |
| sel_map | output | NUM_SECT | Bitmap of sectors selected for erase |

## Verification
Two collisions can fall into the same clock edge.

The first is the expiry of the acceptance window and an additional sector command. The bench sweeps the gap between the first and second sector commands from one cycle up to two cycles past the window length. One point in the sweep places the second command exactly on the expiry edge. The bench expects that command to be accepted and the close time to be recomputed from it. One cycle later, the bench expects the command to be ignored and the bitmap to be left unchanged.

The second collision is the final busy cycle and a suspend request. The bench issues the suspend on that edge. It expects the erase to complete with `ers_susp` staying low.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WIN   = 2'd1,
      ST_ERASE = 2'd2,
      ST_SUSP  = 2'd3
   } ewc_state_t;

   localparam int OP_W = 3;

   localparam logic [OP_W-1:0] OP_NONE   = 3'd0;
   localparam logic [OP_W-1:0] OP_SECT   = 3'd1;
   localparam logic [OP_W-1:0] OP_CHIP   = 3'd2;
   localparam logic [OP_W-1:0] OP_SUSP   = 3'd3;
   localparam logic [OP_W-1:0] OP_RESUME = 3'd4;

endpackage

// File: rtl/ewc_reload_timer.sv
// Down-counter that is reloaded to CYCLES and counts while run is high.
// last marks the final counted cycle.
module ewc_reload_timer #(
   parameter  int CYCLES = 8,
   localparam int CW     = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic last
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= CW'(CYCLES);
      end else if (run && (cnt != '0)) begin
         cnt <= cnt - CW'(1);
      end
   end

   assign last = (cnt == CW'(1));

endmodule

// File: rtl/ewc_sector_map.sv
// One flop per sector; clear has priority over select-all, which has
// priority over a single-bit set.
module ewc_sector_map #(
   parameter  int NUM_SECT = 8,
   localparam int SECT_W   = $clog2(NUM_SECT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [SECT_W-1:0]   set_idx,
   input  logic                set_all,
   input  logic                clr,
   output logic [NUM_SECT-1:0] map
);

   for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            map[i] <= 1'b0;
         end else if (clr) begin
            map[i] <= 1'b0;
         end else if (set_all) begin
            map[i] <= 1'b1;
         end else if (set_en && (set_idx == SECT_W'(i))) begin
            map[i] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ewc_toggle.sv
module ewc_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic flip,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (flip) begin
         q <= ~q;
      end
   end

endmodule

// File: rtl/erase_window_ctl.sv
module erase_window_ctl
   import ewc_pkg::*;
#(
   parameter  int NUM_SECT  = 12,
   parameter  int WIN_CYC   = 50,
   parameter  int ERASE_CYC = 200,
   localparam int SECT_W    = $clog2(NUM_SECT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_vld,
   input  logic [OP_W-1:0]     cmd_op,
   input  logic [SECT_W-1:0]   cmd_sec,
   input  logic                stat_rd,
   output logic                win_open,
   output logic                win_closed,
   output logic                ers_susp,
   output logic                tgl_bit,
   output logic [NUM_SECT-1:0] sel_map
);

   localparam logic [SECT_W:0] SECT_LIM = (SECT_W + 1)'(NUM_SECT);

   if (NUM_SECT < 2) begin : g_bad_sect
      $error("erase_window_ctl: NUM_SECT must be at least 2");
   end
   if (WIN_CYC < 2) begin : g_bad_win
      $error("erase_window_ctl: WIN_CYC must be at least 2");
   end
   if (ERASE_CYC < 2) begin : g_bad_erase
      $error("erase_window_ctl: ERASE_CYC must be at least 2");
   end

   ewc_state_t st, st_nx;

   logic sect_ok, chip_req, susp_req, resume_req;
   logic win_last, busy_last;
   logic win_load, chip_go, win_expire, busy_load, busy_done;

   assign sect_ok    = cmd_vld && (cmd_op == OP_SECT) && ({1'b0, cmd_sec} < SECT_LIM);
   assign chip_req   = cmd_vld && (cmd_op == OP_CHIP);
   assign susp_req   = cmd_vld && (cmd_op == OP_SUSP);
   assign resume_req = cmd_vld && (cmd_op == OP_RESUME);

   assign win_load   = sect_ok && ((st == ST_IDLE) || (st == ST_WIN));
   assign chip_go    = chip_req && !sect_ok && (st == ST_IDLE);
   assign win_expire = (st == ST_WIN) && win_last && !sect_ok;
   assign busy_load  = win_expire || chip_go;
   assign busy_done  = (st == ST_ERASE) && busy_last;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (sect_ok) st_nx = ST_WIN;
                   else if (chip_go) st_nx = ST_ERASE;
         ST_WIN:   if (win_expire) st_nx = ST_ERASE;
         ST_ERASE: if (busy_done) st_nx = ST_IDLE;
                   else if (susp_req) st_nx = ST_SUSP;
         ST_SUSP:  if (resume_req) st_nx = ST_ERASE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
      end else begin
         st <= st_nx;
      end
   end

   ewc_reload_timer #(.CYCLES(WIN_CYC)) u_win_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (win_load),
      .run   (st == ST_WIN),
      .last  (win_last)
   );

   ewc_reload_timer #(.CYCLES(ERASE_CYC)) u_busy_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (busy_load),
      .run   (st == ST_ERASE),
      .last  (busy_last)
   );

   ewc_sector_map #(.NUM_SECT(NUM_SECT)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (win_load),
      .set_idx (cmd_sec),
      .set_all (chip_go),
      .clr     (busy_done),
      .map     (sel_map)
   );

   ewc_toggle u_tgl (
      .clk   (clk),
      .rst_n (rst_n),
      .flip  (stat_rd && (st == ST_ERASE)),
      .q     (tgl_bit)
   );

   assign win_open   = (st == ST_WIN);
   assign win_closed = (st == ST_ERASE) || (st == ST_SUSP);
   assign ers_susp   = (st == ST_SUSP);

endmodule

// File: rtl/ewc_checker.sv
module ewc_checker
   import ewc_pkg::*;
#(
   parameter  int NUM_SECT = 12,
   localparam int SECT_W   = $clog2(NUM_SECT)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_vld,
   input logic [OP_W-1:0]     cmd_op,
   input logic [SECT_W-1:0]   cmd_sec,
   input logic                stat_rd,
   input logic                win_open,
   input logic                win_closed,
   input logic                ers_susp,
   input logic                tgl_bit,
   input logic [NUM_SECT-1:0] sel_map
);

   // R3
   open_closed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_open && win_closed));

   // R2
   open_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(cmd_vld && (cmd_op == OP_SECT)
                                && ({1'b0, cmd_sec} < (SECT_W + 1)'(NUM_SECT))));

   // R7
   map_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(win_closed) |-> (sel_map == '0));

   // R8
   map_frozen_in_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(win_closed) && win_closed) |-> $stable(sel_map));

   // R9
   susp_within_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ers_susp |-> win_closed);

   // R10
   toggle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tgl_bit) |-> $past(stat_rd && win_closed && !ers_susp));

endmodule

bind erase_window_ctl ewc_checker #(.NUM_SECT(NUM_SECT)) u_ewc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_vld    (cmd_vld),
   .cmd_op     (cmd_op),
   .cmd_sec    (cmd_sec),
   .stat_rd    (stat_rd),
   .win_open   (win_open),
   .win_closed (win_closed),
   .ers_susp   (ers_susp),
   .tgl_bit    (tgl_bit),
   .sel_map    (sel_map)
);

// File: tb/sim_erase_window_ctl.sv
`timescale 1ns/100ps
module sim_erase_window_ctl;

   localparam int NS = 6;
   localparam int W  = 5;
   localparam int E  = 7;
   localparam int SW = $clog2(NS);

   localparam logic [2:0] C_NONE = 3'd0, C_SECT = 3'd1, C_CHIP = 3'd2,
                          C_SUSP = 3'd3, C_RES  = 3'd4, C_ODD  = 3'd6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_vld = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [SW-1:0] cmd_sec = '0;
   logic          stat_rd = 1'b0;
   logic          win_open, win_closed, ers_susp, tgl_bit;
   logic [NS-1:0] sel_map;

   int cyc = 0;
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   erase_window_ctl #(.NUM_SECT(NS), .WIN_CYC(W), .ERASE_CYC(E)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
      .cmd_sec(cmd_sec), .stat_rd(stat_rd), .win_open(win_open),
      .win_closed(win_closed), .ers_susp(ers_susp), .tgl_bit(tgl_bit),
      .sel_map(sel_map)
   );

   function automatic logic [31:0] mk(input logic o, c, s, t, input logic [7:0] m);
      return {20'd0, o, c, s, t, m};
   endfunction

   function automatic logic [31:0] obs();
      return mk(win_open, win_closed, ers_susp, tgl_bit, 8'(sel_map));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cmd(input logic [2:0] op, input logic [SW-1:0] sec);
      cmd_vld = 1'b1;
      cmd_op  = op;
      cmd_sec = sec;
      @(negedge clk);
      cmd_vld = 1'b0;
      cmd_op  = '0;
   endtask

   task automatic rd();
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int t0, L, s, r, fin;
      logic [7:0] em;

      do_reset();
      chk("R1 reset state", obs(), mk(0, 0, 0, 0, 8'h00));

      // R5 / R11: ignored commands while idle
      cmd(C_SECT, 3'd6);
      cmd(C_SECT, 3'd7);
      cmd(C_NONE, 3'd1);
      cmd(C_SUSP, 3'd0);
      cmd(C_RES,  3'd0);
      cmd(C_ODD,  3'd2);
      chk("R5 R11 idle ignores", obs(), mk(0, 0, 0, 0, 8'h00));
      rd();
      chk("R10 read while idle", obs(), mk(0, 0, 0, 0, 8'h00));

      // R2 R3 R4 R7: sweep of the gap between two sector commands
      for (int g = 1; g <= W + 2; g++) begin
         do_reset();
         cmd(C_SECT, 3'd1);
         t0 = cyc;
         chk("R2 window opens", obs(), mk(1, 0, 0, 0, 8'h02));
         wait_to(t0 + g - 1);
         cmd(C_SECT, 3'd4);
         L  = (g <= W) ? t0 + g : t0;
         em = (g <= W) ? 8'h12 : 8'h02;
         if (g <= W)
            chk("R4 added sector", obs(), mk(1, 0, 0, 0, em));
         else
            chk("R8 late sector dropped", obs(), mk(0, 1, 0, 0, em));
         if (cyc <= L + W - 1) begin
            wait_to(L + W - 1);
            chk("R4 still open before restart end", obs(), mk(1, 0, 0, 0, em));
         end
         wait_to(L + W);
         chk("R3 window closed", obs(), mk(0, 1, 0, 0, em));
         wait_to(L + W + E - 1);
         chk("R7 busy last cycle", obs(), mk(0, 1, 0, 0, em));
         wait_to(L + W + E);
         chk("R7 erase complete", obs(), mk(0, 0, 0, 0, 8'h00));
      end

      // R11 / R5: other commands inside the window neither add nor restart
      do_reset();
      cmd(C_SECT, 3'd2);
      t0 = cyc;
      cmd(C_CHIP, 3'd0);
      cmd(C_SUSP, 3'd0);
      cmd(C_SECT, 3'd7);
      chk("R11 window ignores others", obs(), mk(1, 0, 0, 0, 8'h04));
      wait_to(t0 + W - 1);
      chk("R5 no restart", obs(), mk(1, 0, 0, 0, 8'h04));
      wait_to(t0 + W);
      chk("R5 close time kept", obs(), mk(0, 1, 0, 0, 8'h04));

      // R6 R8 R10 R7: chip erase path
      do_reset();
      cmd(C_CHIP, 3'd3);
      t0 = cyc;
      chk("R6 chip erase starts at once", obs(), mk(0, 1, 0, 0, 8'h3F));
      rd();
      chk("R10 first read toggles", obs(), mk(0, 1, 0, 1, 8'h3F));
      rd();
      chk("R10 second read toggles", obs(), mk(0, 1, 0, 0, 8'h3F));
      rd();
      chk("R10 third read toggles", obs(), mk(0, 1, 0, 1, 8'h3F));
      cmd(C_SECT, 3'd0);
      cmd(C_CHIP, 3'd0);
      cmd(C_RES,  3'd0);
      chk("R8 erase ignores others", obs(), mk(0, 1, 0, 1, 8'h3F));
      wait_to(t0 + E - 1);
      chk("R7 chip busy last cycle", obs(), mk(0, 1, 0, 1, 8'h3F));
      wait_to(t0 + E);
      chk("R7 chip complete", obs(), mk(0, 0, 0, 1, 8'h00));
      rd();
      chk("R10 read after completion", obs(), mk(0, 0, 0, 1, 8'h00));

      // R9: suspend and resume extend the busy period exactly
      do_reset();
      cmd(C_SECT, 3'd5);
      t0 = cyc;
      wait_to(t0 + W + 1);
      cmd(C_SUSP, 3'd0);
      s = cyc;
      chk("R9 suspended", obs(), mk(0, 1, 1, 0, 8'h20));
      rd();
      chk("R10 read while suspended", obs(), mk(0, 1, 1, 0, 8'h20));
      cmd(C_SECT, 3'd0);
      cmd(C_SUSP, 3'd0);
      cmd(C_CHIP, 3'd0);
      chk("R9 suspend ignores others", obs(), mk(0, 1, 1, 0, 8'h20));
      wait_to(s + 6);
      cmd(C_RES, 3'd0);
      r = cyc;
      chk("R9 resumed", obs(), mk(0, 1, 0, 0, 8'h20));
      fin = (t0 + W) + E + (r - s);
      wait_to(fin - 1);
      chk("R9 busy before delayed end", obs(), mk(0, 1, 0, 0, 8'h20));
      wait_to(fin);
      chk("R9 delayed completion", obs(), mk(0, 0, 0, 0, 8'h00));

      // R9: suspend on the final busy cycle is dropped
      do_reset();
      cmd(C_CHIP, 3'd0);
      t0 = cyc;
      wait_to(t0 + E - 1);
      cmd(C_SUSP, 3'd0);
      chk("R9 late suspend dropped", obs(), mk(0, 0, 0, 0, 8'h00));
      cmd(C_RES, 3'd0);
      chk("R11 resume while idle", obs(), mk(0, 0, 0, 0, 8'h00));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule